// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block finds the divider settings for a frequency synthesizer. Given a reference clock frequency and a requested output frequency, both as whole kilohertz, it picks a post-VCO divide factor that raises the requested frequency into the oscillator's legal window. It then walks every candidate reference divisor, derives the matching feedback divisor, and keeps the pair whose synthesized frequency lies closest to the request.

A search is launched with a one-cycle `start` pulse while the engine is idle. It runs for several thousand cycles on a single shared bit-serial restoring divider, which produces the feedback divisor and then the resulting oscillator frequency in turn. At the end it raises `done` for one cycle. The chosen settings, the resulting oscillator frequency, the signed error and the flags stay on the outputs until the next search begins.

Top module: `pll_divisor_search`

## Requirements
- R1: A reference below 1000 kHz or above 83000 kHz ends the search at once with `ref_err`=1 and `valid`=0. References of exactly 1000 or 83000 are accepted and give `ref_err`=0.
- R2: The post divide P is the smallest of 1, 2, 4 and 8 for which target×P ≥ 100000. It is reported as the value itself in `p_div`. If the target is 0, is above 220000, or gives target×8 < 100000, no P exists and the result is `valid`=0 with `ref_err`=0. The VCO goal is VT = target×P.
- R3: Divisors N are tried in ascending order from 3 to 257. An N is skipped unless 150×N ≤ ref ≤ 5000×N.
- R4: For each N that is tried, M = floor((2×VT×N + ref) / (2×ref)). The pair is discarded unless 3 ≤ M ≤ 257.
- R5: A pair is kept only if 100000×N ≤ ref×M ≤ 220000×N, so the reported VCO lies in 100000..220000 kHz.
- R6: Each surviving pair has X = floor(16×ref×M / N) and cost |X − 16×VT|. The pair with the lowest cost wins. On equal cost, the smaller N wins.
- R7: `vco_khz` = floor(X/16). `err_khz` = floor((X − 16×VT + 2^(s−1)) / 2^s) with s = 4 + log2(P), which is the synthesized output minus the request, rounded.
- R8: `start` is taken only when `busy` is 0. A `start` while busy has no effect on the result. `done` lasts one cycle and falls in a cycle where `busy` is 0. Outputs hold until the next search ends.
- R9: If no pair survives, `done` rises with `valid`=0, and `m_div`, `n_div`, `p_div`, `vco_khz` and `err_khz` are all 0.
- R10: A 14318 kHz reference and a 25175 kHz target give M=211, N=30, P=4 with `valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a search (taken while idle) |
| ref_khz | input | 17 | Reference frequency, kHz |
| tgt_khz | input | 18 | Requested output frequency, kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| valid | output | 1 | A legal setting was found |
| ref_err | output | 1 | Reference outside its accepted range |
| m_div | output | 9 | Feedback divisor |
| n_div | output | 9 | Reference divisor |
| p_div | output | 4 | Post divide factor (1, 2, 4, 8) |
| vco_khz | output | 18 | Resulting oscillator frequency, kHz |
| err_khz | output | 20 | Signed output error, kHz |

## Verification
The end-of-search report and the acceptance of a new request can fall in the same cycle. `done` is raised while the engine is already idle, so a `start` presented in that cycle launches the next search. The bench drives `start` in exactly the cycle where it sees `done`. It judges the first result in that cycle, then checks that the second search runs and returns the arithmetic model's answer for its own inputs, with nothing carried over from the first.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
    localparam int REF_W  = 17;
    localparam int TGT_W  = 18;
    localparam int MN_W   = 9;
    localparam int DIV_W  = 29;
    localparam int VX_W   = 23;
    localparam int ERR_W  = 20;
    localparam int FRAC   = 4;
    localparam int NPOST  = 4;
    localparam int SH_W   = $clog2(NPOST);

    localparam int REF_LO = 1000;
    localparam int REF_HI = 83000;
    localparam int VCO_LO = 100000;
    localparam int VCO_HI = 220000;
    localparam int PFD_LO = 150;
    localparam int PFD_HI = 5000;
    localparam int MN_LO  = 3;
    localparam int MN_HI  = 257;

    typedef enum logic [2:0] {
        S_IDLE, S_NCHK, S_DIVM, S_MCHK, S_DIVV, S_FIN
    } state_t;

    typedef struct packed {
        logic [MN_W-1:0] m;
        logic [MN_W-1:0] n;
        logic [VX_W-1:0] vx;
    } cand_t;
endpackage

// File: rtl/pll_post_sel.sv
module pll_post_sel import pll_srch_pkg::*; #(
    parameter int TW = TGT_W,
    parameter int NP = NPOST,
    localparam int SW = $clog2(NP)
) (
    input  logic [TW-1:0] tgt,
    output logic          ok,
    output logic [SW-1:0] sh,
    output logic [TW-1:0] vt
);
    always_comb begin
        ok = 1'b0;
        sh = '0;
        vt = '0;
        if (tgt != '0 && 32'(tgt) <= 32'(VCO_HI)) begin
            // descending so that the smallest factor that fits wins
            for (int i = NP - 1; i >= 0; i--) begin
                if ((32'(tgt) << i) >= 32'(VCO_LO)) begin
                    ok = 1'b1;
                    sh = SW'(i);
                    vt = TW'(32'(tgt) << i);
                end
            end
        end
    end
endmodule

// File: rtl/pll_div_iter.sv
module pll_div_iter #(
    parameter int DW = 29,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [DW-1:0] quo,
    output logic          rdy
);
    logic [DW:0]   rem_q;
    logic [DW-1:0] wrk_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [DW:0]   trial;

    assign trial = {rem_q[DW-1:0], wrk_q[DW-1]};
    assign quo   = wrk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            wrk_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            rdy   <= 1'b0;
        end else begin
            rdy <= 1'b0;
            if (go) begin
                rem_q <= '0;
                wrk_q <= num;
                den_q <= den;
                cnt_q <= CW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (trial >= {1'b0, den_q}) begin
                    rem_q <= trial - {1'b0, den_q};
                    wrk_q <= {wrk_q[DW-2:0], 1'b1};
                end else begin
                    rem_q <= trial;
                    wrk_q <= {wrk_q[DW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    rdy   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pll_divisor_search.sv
module pll_divisor_search import pll_srch_pkg::*; (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [REF_W-1:0]        ref_khz,
    input  logic [TGT_W-1:0]        tgt_khz,
    output logic                    busy,
    output logic                    done,
    output logic                    valid,
    output logic                    ref_err,
    output logic [MN_W-1:0]         m_div,
    output logic [MN_W-1:0]         n_div,
    output logic [3:0]              p_div,
    output logic [TGT_W-1:0]        vco_khz,
    output logic signed [ERR_W-1:0] err_khz
);
    localparam int XW  = 40;
    localparam int DW1 = VX_W + 1;

    state_t           state_q;
    logic [REF_W-1:0] ref_q;
    logic [TGT_W-1:0] vt_q;
    logic [SH_W-1:0]  sh_q;
    logic [MN_W-1:0]  n_q;
    logic [DIV_W-1:0] mfull_q;
    cand_t            best_q;
    logic [VX_W-1:0]  best_c_q;
    logic             have_q, bad_ref_q;

    logic             ps_ok;
    logic [SH_W-1:0]  ps_sh;
    logic [TGT_W-1:0] ps_vt;

    logic             div_go, div_rdy;
    logic [DIV_W-1:0] div_num, div_den, div_q;

    logic [XW-1:0]    r40, n40, m40, vt40, rm40;
    logic             n_end, pass_n, pass_m;
    logic [VX_W-1:0]  vx_now, t16, cost;
    logic signed [DW1-1:0] dlt, half, errw;
    logic [2:0]       s_sh;

    pll_post_sel #(.TW(TGT_W), .NP(NPOST)) u_post (
        .tgt (tgt_khz),
        .ok  (ps_ok),
        .sh  (ps_sh),
        .vt  (ps_vt)
    );

    pll_div_iter #(.DW(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (div_num),
        .den (div_den),
        .quo (div_q),
        .rdy (div_rdy)
    );

    always_comb begin
        r40    = XW'(ref_q);
        n40    = XW'(n_q);
        m40    = XW'(mfull_q);
        vt40   = XW'(vt_q);
        rm40   = r40 * m40;
        n_end  = n_q > MN_W'(MN_HI);
        pass_n = (XW'(PFD_LO) * n40 <= r40) && (r40 <= XW'(PFD_HI) * n40);
        pass_m = (m40 >= XW'(MN_LO)) && (m40 <= XW'(MN_HI))
              && (rm40 >= XW'(VCO_LO) * n40) && (rm40 <= XW'(VCO_HI) * n40);
        div_go = (state_q == S_NCHK && !n_end && pass_n)
              || (state_q == S_MCHK && pass_m);
        if (state_q == S_NCHK) begin
            div_num = DIV_W'(XW'(2) * vt40 * n40 + r40);
            div_den = DIV_W'(XW'(2) * r40);
        end else begin
            div_num = DIV_W'(rm40 << FRAC);
            div_den = DIV_W'(n40);
        end
        vx_now = VX_W'(div_q);
        t16    = VX_W'(vt40 << FRAC);
        cost   = (vx_now >= t16) ? vx_now - t16 : t16 - vx_now;
        // rounded error scaled back to the output side of the post divide
        s_sh   = 3'(FRAC) + 3'(sh_q);
        dlt    = $signed({1'b0, best_q.vx}) - $signed({1'b0, t16});
        half   = DW1'(1) << (s_sh - 3'd1);
        errw   = (dlt + half) >>> s_sh;
    end

    assign busy = (state_q != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            ref_q     <= '0;
            vt_q      <= '0;
            sh_q      <= '0;
            n_q       <= '0;
            mfull_q   <= '0;
            best_q    <= '0;
            best_c_q  <= '0;
            have_q    <= 1'b0;
            bad_ref_q <= 1'b0;
            done      <= 1'b0;
            valid     <= 1'b0;
            ref_err   <= 1'b0;
            m_div     <= '0;
            n_div     <= '0;
            p_div     <= '0;
            vco_khz   <= '0;
            err_khz   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    ref_q  <= ref_khz;
                    vt_q   <= ps_vt;
                    sh_q   <= ps_sh;
                    n_q    <= MN_W'(MN_LO);
                    have_q <= 1'b0;
                    if (32'(ref_khz) < 32'(REF_LO) || 32'(ref_khz) > 32'(REF_HI)) begin
                        bad_ref_q <= 1'b1;
                        state_q   <= S_FIN;
                    end else begin
                        bad_ref_q <= 1'b0;
                        state_q   <= ps_ok ? S_NCHK : S_FIN;
                    end
                end
                S_NCHK: begin
                    if (n_end)       state_q <= S_FIN;
                    else if (pass_n) state_q <= S_DIVM;
                    else             n_q     <= n_q + 1'b1;
                end
                S_DIVM: if (div_rdy) begin
                    mfull_q <= div_q;
                    state_q <= S_MCHK;
                end
                S_MCHK: begin
                    if (pass_m) state_q <= S_DIVV;
                    else begin
                        n_q     <= n_q + 1'b1;
                        state_q <= S_NCHK;
                    end
                end
                S_DIVV: if (div_rdy) begin
                    if (!have_q || cost < best_c_q) begin
                        best_q.m  <= MN_W'(mfull_q);
                        best_q.n  <= n_q;
                        best_q.vx <= vx_now;
                        best_c_q  <= cost;
                    end
                    have_q  <= 1'b1;
                    n_q     <= n_q + 1'b1;
                    state_q <= S_NCHK;
                end
                S_FIN: begin
                    done    <= 1'b1;
                    valid   <= have_q;
                    ref_err <= bad_ref_q;
                    m_div   <= have_q ? best_q.m : '0;
                    n_div   <= have_q ? best_q.n : '0;
                    p_div   <= have_q ? 4'(4'd1 << sh_q) : '0;
                    vco_khz <= have_q ? TGT_W'(best_q.vx >> FRAC) : '0;
                    err_khz <= have_q ? ERR_W'(errw) : '0;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_srch_chk.sv
module pll_srch_chk import pll_srch_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             valid,
    input logic             ref_err,
    input logic [MN_W-1:0]  m_div,
    input logic [MN_W-1:0]  n_div,
    input logic [3:0]       p_div,
    input logic [TGT_W-1:0] vco_khz
);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_start_taken: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r4_mn_range: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (m_div >= MN_W'(MN_LO) && m_div <= MN_W'(MN_HI)
                          && n_div >= MN_W'(MN_LO) && n_div <= MN_W'(MN_HI)));

    a_r5_vco_window: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (32'(vco_khz) >= 32'(VCO_LO) && 32'(vco_khz) <= 32'(VCO_HI)));

    a_r2_post_pow2: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> ($countones(p_div) == 1));

    a_r1_err_excl: assert property (@(posedge clk) disable iff (rst)
        (done && ref_err) |-> !valid);
endmodule

bind pll_divisor_search pll_srch_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .valid   (valid),
    .ref_err (ref_err),
    .m_div   (m_div),
    .n_div   (n_div),
    .p_div   (p_div),
    .vco_khz (vco_khz)
);

// File: tb/tb_pll_divisor_search.sv
module tb_pll_divisor_search;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [16:0] ref_khz = '0;
    logic [17:0] tgt_khz = '0;
    logic        busy, done, valid, ref_err;
    logic [8:0]  m_div, n_div;
    logic [3:0]  p_div;
    logic [17:0] vco_khz;
    logic signed [19:0] err_khz;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pll_divisor_search dut (
        .clk(clk), .rst(rst), .start(start), .ref_khz(ref_khz), .tgt_khz(tgt_khz),
        .busy(busy), .done(done), .valid(valid), .ref_err(ref_err),
        .m_div(m_div), .n_div(n_div), .p_div(p_div), .vco_khz(vco_khz), .err_khz(err_khz)
    );

    task automatic finish_all();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_done();
        while (!done) begin
            @(negedge clk);
            if (cyc > 190000) begin
                n_chk++;
                n_err++;
                $display("FAIL R8 watchdog: actual=no done expected=done");
                finish_all();
            end
        end
    endtask

    // arithmetic model of R1..R9
    task automatic model(input longint r, input longint t, output longint v, output longint re,
                         output longint m, output longint n, output longint p,
                         output longint vco, output longint e);
        longint vt, bc, bx, mm, x, c, sh, d;
        bit have;
        v = 0; re = 0; m = 0; n = 0; p = 0; vco = 0; e = 0;
        if (r < 1000 || r > 83000) begin re = 1; return; end
        if (t == 0 || t > 220000) return;
        sh = 0;
        while (sh < 3 && (t << sh) < 100000) sh++;
        if ((t << sh) < 100000) return;
        vt = t << sh;
        have = 0; bc = 0; bx = 0;
        for (longint nn = 3; nn <= 257; nn++) begin
            if (150 * nn <= r && r <= 5000 * nn) begin
                mm = (2 * vt * nn + r) / (2 * r);
                if (mm >= 3 && mm <= 257 && r * mm >= 100000 * nn && r * mm <= 220000 * nn) begin
                    x = (16 * r * mm) / nn;
                    c = (x >= 16 * vt) ? x - 16 * vt : 16 * vt - x;
                    if (!have || c < bc) begin
                        have = 1; bc = c; bx = x; m = mm; n = nn;
                    end
                end
            end
        end
        if (!have) begin m = 0; n = 0; return; end
        v = 1;
        p = longint'(1) << sh;
        vco = bx / 16;
        d = bx - 16 * vt;
        e = (d + (longint'(1) << (sh + 3))) >>> (sh + 4);
    endtask

    task automatic compare(longint r, longint t, string tag);
        longint v, re, m, n, p, vco, e;
        model(r, t, v, re, m, n, p, vco, e);
        chk({tag, " R9 valid"}, longint'(valid), v);
        chk({tag, " R1 ref_err"}, longint'(ref_err), re);
        chk({tag, " R4 m"}, longint'(m_div), m);
        chk({tag, " R3 n"}, longint'(n_div), n);
        chk({tag, " R2 p"}, longint'(p_div), p);
        chk({tag, " R5 vco"}, longint'(vco_khz), vco);
        chk({tag, " R7 err"}, longint'(err_khz), e);
    endtask

    task automatic launch(int r, int t);
        @(negedge clk);
        ref_khz = 17'(r);
        tgt_khz = 18'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(int r, int t, string tag);
        launch(r, t);
        wait_done();
        compare(r, t, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset busy", longint'(busy), 0);
        chk("R8 reset done", longint'(done), 0);
        chk("R9 reset valid", longint'(valid), 0);

        // R10 worked example, with explicit values
        run(14318, 25175, "R10");
        chk("R10 m", longint'(m_div), 211);
        chk("R10 n", longint'(n_div), 30);
        chk("R10 p", longint'(p_div), 4);

        // R1 reference window edges
        run(999, 25175, "R1 low");
        run(83001, 25175, "R1 high");
        run(1000, 100000, "R1 edge lo");
        run(83000, 150000, "R1 edge hi");

        // R2 post-divide choices and limits
        run(27000, 12499, "R2 none");
        run(27000, 12500, "R2 p8");
        run(27000, 49999, "R2 p4");
        run(27000, 50000, "R2 p2");
        run(27000, 220000, "R2 p1");
        run(27000, 220001, "R2 over");
        run(27000, 0, "R2 zero");

        // R6 minimum-error search on other refs
        run(14318, 31500, "R6 a");
        run(33333, 65000, "R6 b");

        // R8 start while busy is ignored
        launch(14318, 25175);
        repeat (100) @(negedge clk);
        chk("R8 busy mid-run", longint'(busy), 1);
        ref_khz = 17'(27000);
        tgt_khz = 18'(50000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        compare(14318, 25175, "R8 ignore");

        // R8 start in the done cycle launches the next search
        launch(27000, 40000);
        wait_done();
        compare(27000, 40000, "R8 b2b first");
        ref_khz = 17'(14318);
        tgt_khz = 18'(72000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 b2b busy", longint'(busy), 1);
        wait_done();
        compare(14318, 72000, "R8 b2b second");

        // R8 outputs hold after done
        repeat (20) @(negedge clk);
        compare(14318, 72000, "R8 hold");

        finish_all();
    end
endmodule